// File: doc/BRIEF.md
# Big-to-Little Endian Lane Bridge

This block sits between a big-endian internal bus that is 64 bits wide and a little-endian peripheral bus that is 32 bits wide. Each internal request carries a byte offset of 3 bits, a size code of 3 bits, a read/write flag, a burst flag and 64 bits of write data. The block turns the request into one or two word phases on the peripheral side. Each phase has a word-aligned address, active-low byte enables and byte-reversed data. The phase handshake is valid/ready. When a read finishes, the bytes that were read come back in internal byte order as a 64-bit completion word.

Posted writes are counted in a small occupancy counter. Each accepted write phase adds one, and each drain pulse from downstream takes one away. A burst request is not accepted until that counter reaches zero. A write request is not accepted when its phases could overflow the counter.

Top module: `elb_lane_bridge`

## Requirements
- R1: After reset, `ph_valid` and `cpl_valid` are 0, no phase is pending, and the write occupancy count is zero. A burst request is therefore accepted straight away.
- R2: A size code of 001 to 111 means 1 to 7 bytes, and 000 means 8 bytes. Byte offset k (0..7) is covered when `req_addr` <= k < `req_addr` + size. Requests must satisfy `req_addr` + size <= 8.
- R3: A phase for word h (offsets 4h..4h+3) has `ph_addr` = 4h, that is 000 or 100. `ph_be_n[j]` is 0 exactly when offset 4h+j is covered. For example, 1 byte at offset 000 gives enables 1110, and 1 byte at offset 011 gives 0111.
- R4: `ph_data[8j+7:8j]` equals the internal byte at offset 4h+j, which is `req_wdata[63-8(4h+j) -: 8]`. This holds for all four lanes.
- R5: An access that covers bytes in both words is issued as two phases, word 0 first. An access that covers one word is issued as one phase. `req_ready` stays 0 from acceptance until the last phase is accepted.
- R6: While `ph_valid` is 1 and `ph_ready` is 0, the phase stays offered and its address, enables and data do not change.
- R7: `cpl_valid` pulses for one cycle, in the cycle after the last phase is accepted. For a read, `cpl_rdata[63-8(4h+j) -: 8]` holds `ph_rdata[8j+7:8j]` of phase h for every enabled lane, and all other bytes are zero. For a write, `cpl_rdata` is zero.
- R8: Every accepted write phase increments the occupancy count. Every `wb_drain` pulse decrements it, and a pulse has no effect when the count is zero. A request with `req_burst`=1 keeps `req_ready` at 0 while the count is nonzero.
- R9: A burst request issues one phase for the word that `req_addr[2]` selects. That phase has enables 0000 and `ph_burst`=1.
- R10: A write request keeps `req_ready` at 0 while the count exceeds WB_DEPTH-2, which is 6 by default. Reads are not held by this check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request offered |
| req_ready | output | 1 | Internal request accepted this cycle |
| req_addr | input | 3 | Byte offset within the 64-bit word |
| req_size | input | 3 | Size code (000 = 8 bytes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst request, gated on empty write buffer |
| req_wdata | input | 64 | Big-endian write data |
| cpl_valid | output | 1 | Completion pulse |
| cpl_rdata | output | 64 | Merged big-endian read data |
| ph_valid | output | 1 | Phase offered |
| ph_ready | input | 1 | Phase accepted |
| ph_addr | output | 3 | Word-aligned phase address |
| ph_be_n | output | 4 | Active-low byte enables |
| ph_data | output | 32 | Byte-reversed write data |
| ph_write | output | 1 | Phase is a write |
| ph_burst | output | 1 | Phase belongs to a burst |
| ph_rdata | input | 32 | Little-endian read data, sampled with phase acceptance |
| wb_drain | input | 1 | One posted write has completed |

## Verification
The bench tries every legal combination of offset and size. This exposes a design that misses the split of a straddling access, or that issues the halves in the wrong order or with a stray extra phase. A lane map that is not reversed shows up as enables 0111 where 1110 is due, and as bytes swapped within `ph_data` or `cpl_rdata`.

The bench also checks the write-occupancy counter in three ways:
- It drains the counter past zero. A counter that wraps would then block a later burst for good.
- It brings the counter up to the stall threshold. A threshold that is off by one would let a write through that must wait, or hold one that may go.
- It applies reset in the middle of a write. A design that keeps the count through reset would then refuse the next burst.

// File: rtl/elb_pkg.sv
package elb_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_PHASE} elb_state_e;
endpackage

// File: rtl/elb_lane_decode.sv
module elb_lane_decode #(
  parameter int NLANE = 8,
  parameter int PLANE = 4,
  parameter int AW    = 3
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    size,
  input  logic             burst,
  output logic [NLANE-1:0] mask
);
  localparam int CW = AW + 1;

  logic [CW-1:0] lo, nb, hi;

  assign lo = {1'b0, addr};
  assign nb = (size == '0) ? CW'(NLANE) : {1'b0, size};
  assign hi = lo + nb;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic in_rng, in_word;
    assign in_rng  = (CW'(k) >= lo) && (CW'(k) < hi);
    assign in_word = ((k / PLANE) == (int'(addr) / PLANE));
    assign mask[k] = burst ? in_word : in_rng;
  end
endmodule

// File: rtl/elb_lane_swap.sv
module elb_lane_swap #(
  parameter int IDAT_W = 64,
  parameter int PDAT_W = 32,
  parameter int WSEL   = 1
) (
  input  logic [IDAT_W-1:0] data,
  input  logic [WSEL-1:0]   sel,
  output logic [PDAT_W-1:0] word
);
  localparam int PLANE = PDAT_W / 8;

  always_comb begin
    word = '0;
    for (int j = 0; j < PLANE; j++) begin
      word[8*j +: 8] = data[IDAT_W-8-8*(int'(sel)*PLANE+j) +: 8];
    end
  end
endmodule

// File: rtl/elb_wb_counter.sv
module elb_wb_counter #(
  parameter int WB_DEPTH = 8,
  parameter int CW       = $clog2(WB_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  logic dec_ok;
  assign dec_ok = dec && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec_ok) begin
      cnt <= cnt + 1'b1;
    end else if (!inc && dec_ok) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/elb_lane_bridge.sv
module elb_lane_bridge #(
  parameter int IDAT_W   = 64,
  parameter int PDAT_W   = 32,
  parameter int WB_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [$clog2(IDAT_W/8)-1:0] req_addr,
  input  logic [$clog2(IDAT_W/8)-1:0] req_size,
  input  logic                        req_write,
  input  logic                        req_burst,
  input  logic [IDAT_W-1:0]           req_wdata,
  output logic                        cpl_valid,
  output logic [IDAT_W-1:0]           cpl_rdata,
  output logic                        ph_valid,
  input  logic                        ph_ready,
  output logic [$clog2(IDAT_W/8)-1:0] ph_addr,
  output logic [PDAT_W/8-1:0]         ph_be_n,
  output logic [PDAT_W-1:0]           ph_data,
  output logic                        ph_write,
  output logic                        ph_burst,
  input  logic [PDAT_W-1:0]           ph_rdata,
  input  logic                        wb_drain
);
  import elb_pkg::*;

  localparam int NLANE = IDAT_W / 8;
  localparam int PLANE = PDAT_W / 8;
  localparam int NWORD = NLANE / PLANE;
  localparam int AW    = $clog2(NLANE);
  localparam int WSEL  = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int CW    = $clog2(WB_DEPTH + 1);

  elb_state_e        state_q;
  logic [NLANE-1:0]  req_mask, mask_q;
  logic [IDAT_W-1:0] data_q;
  logic [WSEL-1:0]   word_q, req_word, nxt_word;
  logic [PLANE-1:0]  nxt_lanes;
  logic [PDAT_W-1:0] req_swap, nxt_swap;
  logic [CW-1:0]     wb_cnt;
  logic              nxt_has, accept, ph_fire, wb_full;

  assign req_word  = WSEL'(int'(req_addr) / PLANE);
  assign nxt_word  = word_q + 1'b1;
  assign nxt_lanes = mask_q[int'(nxt_word)*PLANE +: PLANE];
  assign nxt_has   = (int'(word_q) < NWORD - 1) && (|nxt_lanes);

  assign wb_full   = int'(wb_cnt) > (WB_DEPTH - NWORD);
  assign req_ready = (state_q == ST_IDLE)
                   && !(req_burst && (wb_cnt != '0))
                   && !(req_write && wb_full);
  assign accept    = req_valid && req_ready;
  assign ph_fire   = ph_valid && ph_ready;

  elb_lane_decode #(.NLANE(NLANE), .PLANE(PLANE), .AW(AW)) u_decode (
    .addr (req_addr),
    .size (req_size),
    .burst(req_burst),
    .mask (req_mask)
  );

  elb_lane_swap #(.IDAT_W(IDAT_W), .PDAT_W(PDAT_W), .WSEL(WSEL)) u_swap_req (
    .data(req_wdata),
    .sel (req_word),
    .word(req_swap)
  );

  elb_lane_swap #(.IDAT_W(IDAT_W), .PDAT_W(PDAT_W), .WSEL(WSEL)) u_swap_nxt (
    .data(data_q),
    .sel (nxt_word),
    .word(nxt_swap)
  );

  elb_wb_counter #(.WB_DEPTH(WB_DEPTH), .CW(CW)) u_wbcnt (
    .clk(clk),
    .rst(rst),
    .inc(ph_fire && ph_write),
    .dec(wb_drain),
    .cnt(wb_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ph_valid  <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_rdata <= '0;
      mask_q    <= '0;
      data_q    <= '0;
      word_q    <= '0;
      ph_addr   <= '0;
      ph_be_n   <= '1;
      ph_data   <= '0;
      ph_write  <= 1'b0;
      ph_burst  <= 1'b0;
    end else begin
      cpl_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mask_q    <= req_mask;
            data_q    <= req_wdata;
            word_q    <= req_word;
            ph_valid  <= 1'b1;
            ph_addr   <= AW'(int'(req_word) * PLANE);
            ph_be_n   <= ~req_mask[int'(req_word)*PLANE +: PLANE];
            ph_data   <= req_swap;
            ph_write  <= req_write;
            ph_burst  <= req_burst;
            cpl_rdata <= '0;
            state_q   <= ST_PHASE;
          end
        end
        default: begin
          if (ph_fire) begin
            if (!ph_write) begin
              for (int j = 0; j < PLANE; j++) begin
                if (!ph_be_n[j]) begin
                  cpl_rdata[IDAT_W-8-8*(int'(word_q)*PLANE+j) +: 8] <= ph_rdata[8*j +: 8];
                end
              end
            end
            if (nxt_has) begin
              word_q  <= nxt_word;
              ph_addr <= AW'(int'(nxt_word) * PLANE);
              ph_be_n <= ~nxt_lanes;
              ph_data <= nxt_swap;
            end else begin
              ph_valid  <= 1'b0;
              cpl_valid <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/elb_lane_bridge_chk.sv
module elb_lane_bridge_chk #(
  parameter int AW    = 3,
  parameter int PLANE = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             cpl_valid,
  input logic             ph_valid,
  input logic             ph_ready,
  input logic [AW-1:0]    ph_addr,
  input logic [PLANE-1:0] ph_be_n,
  input logic [PLANE*8-1:0] ph_data,
  input logic             ph_burst
);
  localparam int OFS_W = $clog2(PLANE);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ph_valid && !cpl_valid)); // R1

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ph_valid |-> (ph_addr[OFS_W-1:0] == '0)); // R3

  AST_SOME_LANE: assert property (@(posedge clk) disable iff (rst)
    ph_valid |-> (ph_be_n != '1)); // R3

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    ph_valid |-> !req_ready); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && !ph_ready) |=> (ph_valid && $stable(ph_addr) && $stable(ph_be_n) && $stable(ph_data))); // R6

  AST_CPL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |=> !cpl_valid); // R7

  AST_CPL_AFTER_PHASE: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> $past(ph_valid && ph_ready)); // R7

  AST_BURST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && ph_burst) |-> (ph_be_n == '0)); // R9
endmodule

bind elb_lane_bridge elb_lane_bridge_chk #(.AW(AW), .PLANE(PLANE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .cpl_valid(cpl_valid),
  .ph_valid (ph_valid),
  .ph_ready (ph_ready),
  .ph_addr  (ph_addr),
  .ph_be_n  (ph_be_n),
  .ph_data  (ph_data),
  .ph_burst (ph_burst)
);

// File: tb/elb_lane_bridge_tb_top.sv
module elb_lane_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [2:0]  req_addr = '0, req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        ph_ready = 1'b0, wb_drain = 1'b0;
  logic [31:0] ph_rdata = '0;
  logic        req_ready, cpl_valid, ph_valid, ph_write, ph_burst;
  logic [63:0] cpl_rdata;
  logic [2:0]  ph_addr;
  logic [3:0]  ph_be_n;
  logic [31:0] ph_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  elb_lane_bridge dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_burst(req_burst), .req_wdata(req_wdata), .cpl_valid(cpl_valid),
    .cpl_rdata(cpl_rdata), .ph_valid(ph_valid), .ph_ready(ph_ready),
    .ph_addr(ph_addr), .ph_be_n(ph_be_n), .ph_data(ph_data),
    .ph_write(ph_write), .ph_burst(ph_burst), .ph_rdata(ph_rdata),
    .wb_drain(wb_drain)
  );

  // Fields: addr[16:14] size[13:11] first phase addr[10:8] be0[7:4] be1[3:0] (1111 = no second phase)
  localparam logic [16:0] VEC [8] = '{
    {3'd0, 3'd1, 3'd0, 4'b1110, 4'b1111},
    {3'd3, 3'd1, 3'd0, 4'b0111, 4'b1111},
    {3'd5, 3'd1, 3'd4, 4'b1101, 4'b1111},
    {3'd3, 3'd2, 3'd0, 4'b0111, 4'b1110},
    {3'd2, 3'd3, 3'd0, 4'b0011, 4'b1110},
    {3'd0, 3'd0, 3'd0, 4'b0000, 4'b0000},
    {3'd4, 3'd4, 3'd4, 4'b0000, 4'b1111},
    {3'd1, 3'd2, 3'd0, 4'b1001, 4'b1111}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_mask(input int a, input int s);
    int n = (s == 0) ? 8 : s;
    logic [7:0] m = '0;
    for (int k = 0; k < 8; k++) m[k] = (k >= a) && (k < a + n);
    return m;
  endfunction

  function automatic logic [31:0] model_swap(input logic [63:0] d, input int h);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = d[63-8*(4*h+j) -: 8];
    return w;
  endfunction

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wb_drain = 1'b1;
      @(negedge clk) wb_drain = 1'b0;
    end
  endtask

  task automatic run_access(input logic [2:0] a, input logic [2:0] s, input bit wr, input bit bu,
                            input logic [63:0] wd, input logic [31:0] rd0, input logic [31:0] rd1,
                            input logic [2:0] ea0, input logic [3:0] eb0, input logic [3:0] eb1,
                            input int hold);
    logic [63:0] exp_rd = '0;
    logic [3:0]  be_ph [2];
    int          h0, nph, guard;
    h0 = ea0[2];
    nph = (eb1 == 4'hF) ? 1 : 2;
    be_ph[0] = eb0;
    be_ph[1] = eb1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = wr; req_burst = bu; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(req_ready, "R8 request not held forever", {63'd0, req_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int p = 0; p < nph; p++) begin
      int h = h0 + p;
      chk(ph_valid, "R5 phase offered", {63'd0, ph_valid}, 64'd1);
      chk(!req_ready, "R5 ready low while phases pending", {63'd0, req_ready}, 64'd0);
      chk(ph_addr == 3'(4*h), "R3 phase address", {61'd0, ph_addr}, 64'(4*h));
      chk(ph_be_n == be_ph[p], "R3 byte enables", {60'd0, ph_be_n}, {60'd0, be_ph[p]});
      chk(ph_burst == bu, "R9 burst flag", {63'd0, ph_burst}, {63'd0, bu});
      if (wr) chk(ph_data == model_swap(wd, h), "R4 swapped data", {32'd0, ph_data}, {32'd0, model_swap(wd, h)});
      for (int w = 0; w < hold; w++) begin
        @(negedge clk);
        chk(ph_valid && ph_be_n == be_ph[p] && ph_addr == 3'(4*h), "R6 phase held",
            {59'd0, ph_valid, ph_be_n}, {59'd1, be_ph[p]});
      end
      ph_ready = 1'b1;
      ph_rdata = (h == 0) ? rd0 : rd1;
      if (!wr) begin
        for (int j = 0; j < 4; j++)
          if (!be_ph[p][j]) exp_rd[63-8*(4*h+j) -: 8] = ph_rdata[8*j +: 8];
      end
      @(posedge clk);
      @(negedge clk);
      ph_ready = 1'b0;
    end
    chk(!ph_valid, "R5 no extra phase", {63'd0, ph_valid}, 64'd0);
    chk(cpl_valid, "R7 completion pulse", {63'd0, cpl_valid}, 64'd1);
    chk(cpl_rdata == exp_rd, "R7 merged read data", cpl_rdata, exp_rd);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset, burst accepted at once
    @(negedge clk);
    req_burst = 1'b1;
    chk(!ph_valid && !cpl_valid, "R1 outputs idle after reset", {62'd0, ph_valid, cpl_valid}, 64'd0);
    chk(req_ready, "R1 empty buffer lets burst in", {63'd0, req_ready}, 64'd1);
    req_burst = 1'b0;

    // Table walk: writes check lanes and data, then reads check merge
    foreach (VEC[i]) begin
      run_access(VEC[i][16:14], VEC[i][13:11], 1'b1, 1'b0, 64'h0011223344556677, '0, '0,
                 VEC[i][10:8], VEC[i][7:4], VEC[i][3:0], 0);
      drain(2);
      run_access(VEC[i][16:14], VEC[i][13:11], 1'b0, 1'b0, '0, 32'hA3A2A1A0, 32'hB3B2B1B0,
                 VEC[i][10:8], VEC[i][7:4], VEC[i][3:0], (i == 3) ? 3 : 0);
    end

    // R2: every legal offset/size pair against the model
    for (int a = 0; a < 8; a++) begin
      for (int s = 0; s < 8; s++) begin
        if (a + ((s == 0) ? 8 : s) <= 8) begin
          m = model_mask(a, s);
          if (m[3:0] != 0)
            run_access(3'(a), 3'(s), 1'b0, 1'b0, '0, 32'h13121110 + 32'(a), 32'h27262524 + 32'(s),
                       3'd0, ~m[3:0], (m[7:4] != 0) ? ~m[7:4] : 4'hF, 0);
          else
            run_access(3'(a), 3'(s), 1'b0, 1'b0, '0, 32'h0, 32'h27262524 + 32'(s),
                       3'd4, ~m[7:4], 4'hF, 0);
        end
      end
    end

    // R8: burst held while posted writes are outstanding; drain at zero ignored
    run_access(3'd0, 3'd0, 1'b1, 1'b0, 64'h8877665544332211, '0, '0, 3'd0, 4'b0000, 4'b0000, 0);
    @(negedge clk);
    req_valid = 1'b1; req_burst = 1'b1; req_write = 1'b0; req_addr = 3'd4;
    @(negedge clk);
    chk(!req_ready, "R8 burst held with count 2", {63'd0, req_ready}, 64'd0);
    wb_drain = 1'b1;
    @(negedge clk) wb_drain = 1'b0;
    chk(!req_ready, "R8 burst held with count 1", {63'd0, req_ready}, 64'd0);
    wb_drain = 1'b1;
    @(negedge clk) wb_drain = 1'b0;
    chk(req_ready, "R8 burst released at count 0", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b0; req_burst = 1'b0;
    drain(2);
    // R9: burst phase on the upper word
    run_access(3'd4, 3'd0, 1'b0, 1'b1, '0, '0, 32'hDDCCBBAA, 3'd4, 4'b0000, 4'hF, 0);

    // R10: write stall above threshold
    for (int i = 0; i < 4; i++)
      run_access(3'd0, 3'd0, 1'b1, 1'b0, 64'(i), '0, '0, 3'd0, 4'b0000, 4'b0000, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_burst = 1'b0; req_addr = 3'd0; req_size = 3'd1;
    @(negedge clk);
    chk(!req_ready, "R10 write held at count 8", {63'd0, req_ready}, 64'd0);
    req_write = 1'b0;
    #1;
    chk(req_ready, "R10 read not held", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b0; req_write = 1'b1;
    wb_drain = 1'b1;
    @(negedge clk) wb_drain = 1'b0;
    chk(!req_ready, "R10 write held at count 7", {63'd0, req_ready}, 64'd0);
    wb_drain = 1'b1;
    @(negedge clk) wb_drain = 1'b0;
    chk(req_ready, "R10 write allowed at count 6", {63'd0, req_ready}, 64'd1);
    req_write = 1'b0;
    drain(6);

    // R1: reset mid-operation clears phase and count
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_size = 3'd0;
    @(negedge clk);
    req_valid = 1'b0; ph_ready = 1'b1;
    @(negedge clk);
    ph_ready = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!ph_valid && !cpl_valid, "R1 reset drops phase", {62'd0, ph_valid, cpl_valid}, 64'd0);
    req_burst = 1'b1; req_write = 1'b0;
    #1;
    chk(req_ready, "R1 reset empties write count", {63'd0, req_ready}, 64'd1);
    req_burst = 1'b0;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule